// File: doc/BRIEF.md
# Link Speed Detector by Clock Measurement

This block decides whether an Ethernet PHY link runs in gigabit mode (receive clock at 125 MHz, byte-wide data) or in a slower nibble-wide mode (receive clock at least five times slower). It does not read any PHY register. Instead it times the PHY receive clock against the local system clock, whose frequency is a parameter. In the receive domain, a free-running counter marks off windows of 1024 receive-clock cycles. Each window boundary is carried into the system domain as a toggle. A two-stage synchronizer and an edge detector turn that toggle back into a one-cycle pulse. In the system domain, a saturating counter measures how many system cycles each window lasted. That count is compared with a threshold computed at elaboration time.

A small state machine turns each finished window into a decision. It registers the mode bit, raises a one-cycle update strobe, and marks the mode as valid once the first decision has been made. If the receive clock stops, no window pulse arrives. After a bounded number of system cycles a timeout then declares the slow mode, and the state machine waits for the clock to come back.

Top module: `link_speed_detect`

## Requirements
- R1: While reset is applied and in the first cycle after it, `mode_mii` is 0 (0 = gigabit, 1 = slow mode), `mode_valid` is 0 and `mode_update` is 0.
- R2: A decision from measurement is made only after the 1024th rising edge of `rx_clk` since reset, and after each further 1024 edges. No update appears before that edge unless a timeout occurs.
- R3: When the number of system cycles in a window is not above the threshold, the decision sets `mode_mii` to 0. A 125 MHz receive clock gives this result.
- R4: When the window count is above the threshold, the decision sets `mode_mii` to 1. A 25 MHz receive clock gives this result.
- R5: The threshold is floor(SYS_CLK_HZ × 1024 × MARGIN_PERMILLE / (REF_CLK_HZ × 1000)). The multiplication is done before the division, which gives 1720 for 200 MHz, 125 MHz and 1050.
- R6: Each decision raises `mode_update` for exactly one system cycle. `mode_mii` changes only in a cycle where `mode_update` is high.
- R7: `mode_valid` rises together with the first `mode_update` and then stays high until reset.
- R8: If no window boundary arrives within TIMEOUT_CYCLES system cycles, one update is issued with `mode_mii` = 1. No further update follows until a window boundary arrives.
- R9: The first window boundary after a timeout yields `mode_mii` = 1, because it is measured against the saturated count. Later windows are measured normally.
- R10: When a window boundary and the timeout fall in the same system cycle, exactly one update is issued, with `mode_mii` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Local system clock of known frequency |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| rx_clk | input | 1 | PHY receive clock being measured |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| mode_mii | output | 1 | Detected mode: 0 gigabit, 1 slow nibble mode |
| mode_valid | output | 1 | High once at least one decision has been made |
| mode_update | output | 1 | One-cycle strobe on each new decision |

## Verification
The timeout and the arrival of a window boundary can occur in the same system cycle. The bench provokes this by running 1023 receive edges, holding the receive clock still, and then delivering the last edge at a range of system-cycle offsets just before the timeout limit. For every offset it judges that the final mode is the slow mode, that it is valid, that no update strobe ever lasts two cycles, and that only one or two strobes appear in total. A bound assertion checks the exact coincident cycle: a single strobe with the slow mode.

// File: rtl/link_speed_pkg.sv
`timescale 1ns/1ps
package link_speed_pkg;

    typedef enum logic [1:0] {
        ST_MEASURE = 2'd0,
        ST_DETECT  = 2'd1,
        ST_STALLED = 2'd2
    } det_state_e;

    typedef enum logic {
        LINK_GIG  = 1'b0,
        LINK_SLOW = 1'b1
    } link_mode_e;

    typedef struct packed {
        logic window_end;
        logic timed_out;
        logic over_limit;
    } meter_flags_t;

    // Multiply first, divide last, so a non-integer clock ratio keeps its precision.
    function automatic longint unsigned calc_threshold(
        input longint unsigned sys_hz,
        input longint unsigned ref_hz,
        input int unsigned     win_log2,
        input int unsigned     margin_pm
    );
        longint unsigned num;
        num = sys_hz * (64'd1 << win_log2) * longint'(margin_pm);
        return num / (ref_hz * 64'd1000);
    endfunction

endpackage

// File: rtl/link_speed_rx_window.sv
`timescale 1ns/1ps
module link_speed_rx_window #(
    parameter int unsigned WIN_LOG2 = 10
) (
    input  logic rx_clk,
    input  logic rx_rst,
    output logic win_toggle
);
    logic [WIN_LOG2-1:0] edge_cnt;

    always_ff @(posedge rx_clk) begin
        if (rx_rst) begin
            edge_cnt   <= '0;
            win_toggle <= 1'b0;
        end else begin
            edge_cnt <= edge_cnt + 1'b1;
            if (&edge_cnt) begin
                win_toggle <= ~win_toggle;
            end
        end
    end
endmodule

// File: rtl/link_speed_pulse_sync.sv
`timescale 1ns/1ps
module link_speed_pulse_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_toggle,
    output logic pulse
);
    // Bits [STAGES-1:0] resynchronise the toggle; bit STAGES remembers the last level.
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], async_toggle};
        end
    end

    assign pulse = shreg[STAGES] ^ shreg[STAGES-1];
endmodule

// File: rtl/link_speed_meter.sv
`timescale 1ns/1ps
module link_speed_meter
    import link_speed_pkg::*;
#(
    parameter int unsigned CNT_W     = 17,
    parameter int unsigned THRESH    = 1720,
    parameter int unsigned LIMIT_CNT = 131072
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         win_pulse,
    output meter_flags_t flags
);
    localparam logic [CNT_W-1:0] THRESH_C = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] LIMIT_C  = CNT_W'(LIMIT_CNT);

    logic [CNT_W-1:0] sys_cnt;

    always_ff @(posedge clk) begin
        if (rst || win_pulse) begin
            sys_cnt <= '0;
        end else if (sys_cnt != LIMIT_C) begin
            sys_cnt <= sys_cnt + 1'b1;
        end
    end

    always_comb begin
        flags.window_end = win_pulse;
        flags.timed_out  = (sys_cnt == LIMIT_C);
        flags.over_limit = (sys_cnt > THRESH_C);
    end
endmodule

// File: rtl/link_speed_fsm.sv
`timescale 1ns/1ps
module link_speed_fsm
    import link_speed_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  meter_flags_t flags,
    output logic         mode_mii,
    output logic         mode_valid,
    output logic         mode_update
);
    det_state_e state_q, state_d;
    link_mode_e mode_q, verdict;
    logic       valid_q;
    logic       stall_q;

    always_comb begin
        state_d = state_q;
        verdict = mode_q;
        unique case (state_q)
            ST_MEASURE: begin
                if (flags.window_end) begin
                    state_d = ST_DETECT;
                    verdict = flags.over_limit ? LINK_SLOW : LINK_GIG;
                end else if (flags.timed_out) begin
                    state_d = ST_DETECT;
                    verdict = LINK_SLOW;
                end
            end
            ST_DETECT: begin
                state_d = stall_q ? ST_STALLED : ST_MEASURE;
            end
            ST_STALLED: begin
                if (flags.window_end) begin
                    state_d = ST_DETECT;
                    verdict = flags.over_limit ? LINK_SLOW : LINK_GIG;
                end
            end
            default: state_d = ST_MEASURE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_MEASURE;
            mode_q  <= LINK_GIG;
            valid_q <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_DETECT && state_d == ST_DETECT) begin
                mode_q  <= verdict;
                valid_q <= 1'b1;
                stall_q <= ~flags.window_end;
            end
        end
    end

    assign mode_mii    = (mode_q == LINK_SLOW);
    assign mode_valid  = valid_q;
    assign mode_update = (state_q == ST_DETECT);
endmodule

// File: rtl/link_speed_detect.sv
`timescale 1ns/1ps
module link_speed_detect
    import link_speed_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ      = 200_000_000,
    parameter longint unsigned REF_CLK_HZ      = 125_000_000,
    parameter int unsigned     WIN_LOG2        = 10,
    parameter int unsigned     MARGIN_PERMILLE = 1050,
    parameter int unsigned     TIMEOUT_CYCLES  = 131072,
    parameter int unsigned     SYNC_STAGES     = 2
) (
    input  logic sys_clk,
    input  logic sys_rst,
    input  logic rx_clk,
    input  logic rx_rst,
    output logic mode_mii,
    output logic mode_valid,
    output logic mode_update
);
    localparam longint unsigned THRESH_L =
        calc_threshold(SYS_CLK_HZ, REF_CLK_HZ, WIN_LOG2, MARGIN_PERMILLE);
    localparam int unsigned THRESH = int'(THRESH_L);
    localparam int unsigned CNT_W  = $clog2(TIMEOUT_CYCLES + 1);

    logic         win_toggle;
    logic         win_pulse;
    logic         timeout_hit;
    meter_flags_t flags;

    link_speed_rx_window #(.WIN_LOG2(WIN_LOG2)) u_rx_window (
        .rx_clk     (rx_clk),
        .rx_rst     (rx_rst),
        .win_toggle (win_toggle)
    );

    link_speed_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (sys_clk),
        .rst          (sys_rst),
        .async_toggle (win_toggle),
        .pulse        (win_pulse)
    );

    link_speed_meter #(
        .CNT_W     (CNT_W),
        .THRESH    (THRESH),
        .LIMIT_CNT (TIMEOUT_CYCLES)
    ) u_meter (
        .clk       (sys_clk),
        .rst       (sys_rst),
        .win_pulse (win_pulse),
        .flags     (flags)
    );

    assign timeout_hit = flags.timed_out;

    link_speed_fsm u_fsm (
        .clk         (sys_clk),
        .rst         (sys_rst),
        .flags       (flags),
        .mode_mii    (mode_mii),
        .mode_valid  (mode_valid),
        .mode_update (mode_update)
    );
endmodule

// File: rtl/link_speed_checker.sv
`timescale 1ns/1ps
module link_speed_checker (
    input logic sys_clk,
    input logic sys_rst,
    input logic mode_mii,
    input logic mode_valid,
    input logic mode_update,
    input logic win_pulse,
    input logic timeout_hit
);
    AST_UPDATE_SINGLE: assert property (@(posedge sys_clk) disable iff (sys_rst)
        mode_update |=> !mode_update); // R6

    AST_MODE_HOLD: assert property (@(posedge sys_clk) disable iff (sys_rst)
        !mode_update |-> $stable(mode_mii)); // R6

    AST_VALID_STICKY: assert property (@(posedge sys_clk) disable iff (sys_rst)
        mode_valid |=> mode_valid); // R7

    AST_VALID_FIRST: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $rose(mode_valid) |-> mode_update); // R7

    AST_TIMEOUT_SLOW: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (timeout_hit && !win_pulse && !mode_valid) |=> (mode_update && mode_mii)); // R8

    AST_COINCIDE: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (win_pulse && timeout_hit && !mode_update) |=> (mode_update && mode_mii)); // R10
endmodule

bind link_speed_detect link_speed_checker u_checker (
    .sys_clk     (sys_clk),
    .sys_rst     (sys_rst),
    .mode_mii    (mode_mii),
    .mode_valid  (mode_valid),
    .mode_update (mode_update),
    .win_pulse   (win_pulse),
    .timeout_hit (timeout_hit)
);

// File: tb/tb_link_speed_detect.sv
`timescale 1ns/1ps
module tb_link_speed_detect;
    localparam int unsigned TO = 12000;
    localparam real SYS_PER = 5.0;

    logic sys_clk = 1'b0;
    logic sys_rst = 1'b1;
    logic rx_clk  = 1'b0;
    logic rx_rst  = 1'b1;
    logic mode_mii, mode_valid, mode_update;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  upd_cnt  = 0;
    int  sys_cyc  = 0;
    bit  dbl_upd  = 1'b0;
    bit  prev_upd = 1'b0;
    bit  done     = 1'b0;

    always #(SYS_PER/2.0) sys_clk = ~sys_clk;

    link_speed_detect #(.TIMEOUT_CYCLES(TO)) dut (
        .sys_clk     (sys_clk),
        .sys_rst     (sys_rst),
        .rx_clk      (rx_clk),
        .rx_rst      (rx_rst),
        .mode_mii    (mode_mii),
        .mode_valid  (mode_valid),
        .mode_update (mode_update)
    );

    // Single process owns the monitor counters.
    always @(posedge sys_clk) begin
        if (sys_rst) begin
            upd_cnt  <= 0;
            sys_cyc  <= 0;
            dbl_upd  <= 1'b0;
            prev_upd <= 1'b0;
        end else begin
            sys_cyc  <= sys_cyc + 1;
            prev_upd <= mode_update;
            if (mode_update) upd_cnt <= upd_cnt + 1;
            if (mode_update && prev_upd) dbl_upd <= 1'b1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rx_edges(input int n, input real half);
        repeat (n) begin
            #(half) rx_clk = 1'b1;
            #(half) rx_clk = 1'b0;
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(posedge sys_clk);
        #1;
    endtask

    task automatic do_reset();
        sys_rst = 1'b1;
        rx_rst  = 1'b1;
        rx_edges(4, 4.0);
        wait_sys(8);
        sys_rst = 1'b0;
        rx_rst  = 1'b0;
    endtask

    // Expected verdict from the requirement: count = window time / system period.
    function automatic int exp_slow(input real rx_period);
        real thr;
        real cnt;
        thr = $floor(200.0e6 * 1024.0 * 1050.0 / (125.0e6 * 1000.0));
        cnt = 1024.0 * rx_period / SYS_PER;
        return (cnt > thr) ? 1 : 0;
    endfunction

    task automatic t_reset();
        do_reset();
        wait_sys(1);
        chk("R1 mode", int'(mode_mii), 0);
        chk("R1 valid", int'(mode_valid), 0);
        chk("R1 update", int'(mode_update), 0);
    endtask

    task automatic t_gig();
        do_reset();
        rx_edges(1023, 4.0);
        wait_sys(20);
        chk("R2 no update before window end", upd_cnt, 0);
        chk("R2 not valid before window end", int'(mode_valid), 0);
        rx_edges(1, 4.0);
        wait_sys(20);
        chk("R2 update after 1024 edges", upd_cnt, 1);
        chk("R7 valid after first update", int'(mode_valid), 1);
        rx_edges(1024, 4.0);
        wait_sys(20);
        chk("R2 second window update", upd_cnt, 2);
        chk("R3 gigabit decision", int'(mode_mii), 0);
        chk("R6 single-cycle strobe", int'(dbl_upd), 0);
    endtask

    task automatic t_slow();
        do_reset();
        rx_edges(2048, 20.0);
        wait_sys(20);
        chk("R4 two slow windows", upd_cnt, 2);
        chk("R4 slow decision", int'(mode_mii), 1);
        chk("R7 valid stays", int'(mode_valid), 1);
        chk("R6 single-cycle strobe", int'(dbl_upd), 0);
    endtask

    task automatic t_margin(input real half);
        do_reset();
        rx_edges(2048, half);
        wait_sys(20);
        chk("R5 near-threshold updates", upd_cnt, 2);
        chk("R5 near-threshold verdict", int'(mode_mii), exp_slow(2.0 * half));
    endtask

    task automatic t_timeout();
        do_reset();
        wait_sys(TO - 50);
        chk("R8 no update before timeout", upd_cnt, 0);
        chk("R8 not valid before timeout", int'(mode_valid), 0);
        wait_sys(100);
        chk("R8 one update at timeout", upd_cnt, 1);
        chk("R8 timeout selects slow", int'(mode_mii), 1);
        chk("R7 valid after timeout", int'(mode_valid), 1);
        wait_sys(3000);
        chk("R8 no repeated timeout update", upd_cnt, 1);
        rx_edges(1024, 4.0);
        wait_sys(20);
        chk("R9 first window after stall", upd_cnt, 2);
        chk("R9 first window after stall is slow", int'(mode_mii), 1);
        rx_edges(1024, 4.0);
        wait_sys(20);
        chk("R9 next window measured", upd_cnt, 3);
        chk("R9 next window gigabit", int'(mode_mii), 0);
    endtask

    task automatic t_coincide();
        for (int d = 1; d <= 6; d++) begin
            do_reset();
            rx_edges(1023, 4.0);
            while (sys_cyc < TO - d) @(posedge sys_clk);
            rx_edges(1, 1.0);
            wait_sys(50);
            chk("R10 final mode slow", int'(mode_mii), 1);
            chk("R10 valid", int'(mode_valid), 1);
            chk("R10 strobe count 1 or 2", int'(upd_cnt >= 1 && upd_cnt <= 2), 1);
            chk("R6 no merged strobe", int'(dbl_upd), 0);
        end
    endtask

    initial begin
        t_reset();
        t_gig();
        t_slow();
        t_margin(4.4);
        t_margin(4.1);
        t_coincide();
        t_timeout();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(190000.0 * SYS_PER);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule